// File: doc/BRIEF.md
# Subtractive GCD Unit with Handshake

This block computes the greatest common divisor of two unsigned operands by repeated subtraction, one step per clock cycle. A requester presents both operands with a request flag and keeps the flag high until the block acknowledges it. The operands are taken in the same cycle as the acknowledge.

The block then runs its iteration. While the two working values differ, the larger one is reduced by the smaller one. When the values are equal, or when one of them is zero, the block stops and presents the result under a valid flag. The result and the flag stay put until the reader signals acceptance. The block then goes back to waiting for the next request.

A single clocked process holds the control state, the two working registers and the result register. The comparator and the subtractor are plain combinational logic in front of those registers.

Top module: `gcd_sub_unit`

## Requirements
- R1: After reset, `res_valid` and `req_ack` are low and the block waits in its idle state for a request.
- R2: `req_ack` is high in exactly those cycles where the block is idle and `req_valid` is high. The operands on `opa` and `opb` are captured at the clock edge that ends such a cycle.
- R3: For two nonzero operands, `res_data` equals their greatest common divisor when `res_valid` rises.
- R4: Each cycle of iteration takes one subtraction: the larger working value is replaced by the difference. For nonzero operands that need S subtractions, `res_valid` first becomes high S+1 clock edges after the capturing edge.
- R5: If either operand is zero, the result is the other operand (zero when both are zero). `res_valid` becomes high one clock edge after the capturing edge.
- R6: While `res_valid` is high and `res_accept` is low, `res_valid` stays high and `res_data` does not change.
- R7: A cycle with both `res_valid` and `res_accept` high ends the transaction. `res_valid` is low after the next edge, and a pending request is acknowledged in the following cycle.
- R8: While the block is iterating or holding a result, `req_ack` stays low whatever `req_valid` does. Changes on `opa` and `opb` in those cycles do not alter the result.
- R9: `res_accept` has no effect while `res_valid` is low: asserting it during the iteration changes neither the result nor its latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request; held high by the requester until acknowledged |
| opa | input | W | First operand, unsigned |
| opb | input | W | Second operand, unsigned |
| res_accept | input | 1 | Reader takes the result in a cycle where res_valid is high |
| req_ack | output | 1 | Operands taken at the end of this cycle |
| res_valid | output | 1 | res_data holds a finished result |
| res_data | output | W | Greatest common divisor of the captured operands |

## Verification
The acknowledge is combinational, so the bench checks it a short delay after it drives a request, in the same cycle. The result of a nonzero pair is due S+1 edges after the capturing edge, where S is the subtraction count found by a bench loop. A pair with a zero operand is due one edge after capture. The bench counts falling edges from the capture and compares the count at which `res_valid` is first seen against that figure. It compares `res_data` there with a Euclid remainder model. After a release, the bench samples one falling edge after the accepting edge and expects `res_valid` low.

// File: rtl/gcd_sub_unit.sv
module gcd_sub_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         res_accept,
  output logic         req_ack,
  output logic         res_valid,
  output logic [W-1:0] res_data
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_t;

  st_t          st;
  logic [W-1:0] a_q, b_q;
  logic         finish, a_gt;
  logic [W:0]   sum_q;

  assign finish    = (a_q == b_q) || (a_q == '0) || (b_q == '0);
  assign a_gt      = a_q > b_q;
  assign sum_q     = {1'b0, a_q} + {1'b0, b_q};
  assign req_ack   = (st == ST_IDLE) && req_valid;
  assign res_valid = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      a_q      <= '0;
      b_q      <= '0;
      res_data <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          a_q <= opa;
          b_q <= opb;
          st  <= ST_RUN;
        end
        ST_RUN: if (finish) begin
          res_data <= a_q | b_q;
          st       <= ST_DONE;
        end else if (a_gt) begin
          a_q <= a_q - b_q;
        end else begin
          b_q <= b_q - a_q;
        end
        ST_DONE: if (res_accept) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_ack_starts_run_R2: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !res_valid && !req_ack);

  assert_step_shrinks_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && !finish) |=> (sum_q < $past(sum_q)));

  assert_hold_result_R6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_accept) |=> (res_valid && $stable(res_data)));

  assert_release_R7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_accept) |=> !res_valid);

  assert_no_ack_busy_R8: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !req_ack);

endmodule

// File: tb/gcd_sub_unit_test.sv
module gcd_sub_unit_test;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int WAIT_MAX = 2 * (1 << W) + 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid, res_accept;
  logic [W-1:0] opa, opb;
  logic         req_ack, res_valid;
  logic [W-1:0] res_data;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  gcd_sub_unit #(.W(W)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .opa(opa), .opb(opb),
    .res_accept(res_accept), .req_ack(req_ack), .res_valid(res_valid),
    .res_data(res_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  function automatic int euclid(int a, int b);
    int t;
    while (b != 0) begin
      t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  function automatic int sub_steps(int a, int b);
    int s = 0;
    if (a == 0 || b == 0) return 0;
    while (a != b) begin
      if (a > b) a = a - b; else b = b - a;
      s++;
    end
    return s;
  endfunction

  task automatic check(bit ok, string req, int actual, int expected);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic run_one(int a, int b, int hold, bit noise);
    int exp_res, exp_lat, cnt;
    exp_res = (a == 0) ? b : (b == 0) ? a : euclid(a, b);
    exp_lat = sub_steps(a, b) + 1;
    @(negedge clk);
    req_valid = 1'b1;
    opa = W'(a);
    opb = W'(b);
    #1;
    check(req_ack === 1'b1, "R2 ack when idle", int'(req_ack), 1);
    @(negedge clk);
    cnt = 0;
    while (!res_valid && cnt < WAIT_MAX) begin
      if (noise) begin
        req_valid  = 1'b1;
        opa        = W'($urandom);
        opb        = W'($urandom);
        res_accept = 1'($urandom);
      end else begin
        req_valid = 1'b0;
      end
      #1;
      if (noise) check(req_ack === 1'b0, "R8 no ack while busy", int'(req_ack), 0);
      @(negedge clk);
      cnt++;
    end
    req_valid  = 1'b0;
    res_accept = 1'b0;
    if (a == 0 || b == 0) begin
      check(cnt == 1, "R5 zero operand latency", cnt, 1);
      check(int'(res_data) == exp_res, "R5 zero operand result", int'(res_data), exp_res);
    end else begin
      check(cnt == exp_lat, noise ? "R9 latency with stray accept" : "R4 latency", cnt, exp_lat);
      check(int'(res_data) == exp_res, noise ? "R8 result despite input noise" : "R3 gcd result",
            int'(res_data), exp_res);
    end
    for (int i = 0; i < hold; i++) begin
      req_valid = 1'b1;
      #1;
      check(req_ack === 1'b0, "R8 no ack while holding", int'(req_ack), 0);
      @(negedge clk);
      check(res_valid === 1'b1 && int'(res_data) == exp_res, "R6 result held",
            int'(res_data), exp_res);
    end
    req_valid  = 1'b0;
    res_accept = 1'b1;
    @(negedge clk);
    res_accept = 1'b0;
    check(res_valid === 1'b0, "R7 release", int'(res_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    req_valid = 1'b0;
    res_accept = 1'b0;
    opa = '0;
    opb = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(res_valid === 1'b0, "R1 reset valid", int'(res_valid), 0);
    check(req_ack === 1'b0, "R1 reset ack", int'(req_ack), 0);
    res_accept = 1'b1;
    @(negedge clk);
    res_accept = 1'b0;
    check(res_valid === 1'b0, "R9 accept while idle", int'(res_valid), 0);

    run_one(48, 18, 3, 1'b0);
    run_one(17, 17, 1, 1'b0);
    run_one(255, 1, 2, 1'b0);
    run_one(1, 255, 0, 1'b1);
    run_one(128, 64, 2, 1'b1);
    run_one(255, 255, 0, 1'b0);
    run_one(0, 9, 2, 1'b0);
    run_one(12, 0, 1, 1'b0);
    run_one(0, 0, 1, 1'b0);
    for (int k = 0; k < 40; k++)
      run_one(int'($urandom_range(255, 1)), int'($urandom_range(255, 1)),
              int'($urandom_range(3, 0)), 1'($urandom));

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule